// File: doc/BRIEF.md
# System-Management Interrupt Entry Unit

This block sits between the pin for system-management interrupts and the core's sequencer. The request input is active low and asynchronous. The block passes it through a synchronizer and turns a falling edge into a single request. After an edge, the detector refuses a new one until the input has stayed inactive for a set number of clocks. The request waits in a one-deep pending slot and is taken at the next instruction boundary.

Taking a request puts the core in management mode. That masks any later request until the resume strobe, and one request that arrives while masked is kept for later. The mode-active output goes high only once the write buffers report empty, and it stays high until the resume strobe. A pending NMI gives way to a system-management request at the same boundary. The block also drives the fixed handler entry address, which is the reset save-area base plus a 0x8000 offset.

Top module: `smi_entry_unit`

## Requirements
- R1: A high-to-low transition on `smi_ni` creates exactly one request. Holding the pin low for any number of clocks creates no further request.
- R2: After an accepted edge, a new falling edge is accepted only if `smi_ni` has first been high for at least `REARM_CLKS` consecutive clocks (default 4). A shorter high pulse followed by a low is ignored.
- R3: `take_o` can be high only in a cycle where `boundary_i` is high, a request is pending and the block is not in management mode. `take_o` is combinational with `boundary_i`.
- R4: With the default two synchronizer stages, a low first sampled at clock edge k is taken by a boundary that is sampled at edge k+3. A boundary sampled at edge k+2 does not take it.
- R5: From the clock after `take_o` until the clock after `resume_i`, `take_o` stays low whatever `boundary_i` does.
- R6: While masked, a single pending request is kept, however many edges arrive. It is taken at the first boundary after the resume strobe, and exactly one extra handler entry results.
- R7: `nmi_take_o` follows `boundary_i & nmi_req_i`, except that it is low in any cycle where `take_o` is high.
- R8: `smiact_o` rises on the clock after a cycle in which the block is in management mode with `wbuf_empty_i` high. It then holds regardless of `wbuf_empty_i`, and falls on the clock after `resume_i`.
- R9: `entry_addr_o` equals `SMBASE_RST + 0x8000`, which is 0x0003_8000 by default.
- R10: While `rst_ni` is low and right after it rises, `take_o` and `smiact_o` are low and no request is pending, even if reset arrived during management mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smi_ni | input | 1 | Asynchronous interrupt request, active low |
| boundary_i | input | 1 | Instruction boundary strobe |
| wbuf_empty_i | input | 1 | Write buffers and pending writes drained |
| resume_i | input | 1 | Resume strobe at the end of the handler |
| nmi_req_i | input | 1 | Pending NMI from the NMI logic |
| take_o | output | 1 | Take system-management interrupt at this boundary |
| nmi_take_o | output | 1 | Take NMI at this boundary |
| smiact_o | output | 1 | Management mode active |
| entry_addr_o | output | 32 | Handler entry address |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a four-clock re-arm window and a save-area base of 0x0003_0000. At these values the three-clock recognition latency can be placed exactly. The re-arm boundary is probed with high pulses of three and four clocks. Two edges can be packed into a single masked period to exercise the one-deep pending slot and the back-to-back entry, all within about forty cycles.

// File: rtl/smi_pkg.sv
package smi_pkg;
  typedef logic [31:0] addr_t;
  localparam addr_t HANDLER_OFS = 32'h0000_8000;

  function automatic addr_t handler_entry(input addr_t base);
    return base + HANDLER_OFS;
  endfunction
endpackage

// File: rtl/smi_sync.sv
module smi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '1;
        else         q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/smi_edge.sv
module smi_edge #(
  parameter int REARM_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smi_sync_ni,
  output logic edge_o
);
  localparam int CNT_W = $clog2(REARM_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REARM_CLKS);

  logic [CNT_W-1:0] hi_cnt;

  // counts consecutive inactive clocks, saturating; reset counts as armed
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 hi_cnt <= CNT_MAX;
    else if (!smi_sync_ni)       hi_cnt <= '0;
    else if (hi_cnt != CNT_MAX)  hi_cnt <= hi_cnt + 1'b1;

  assign edge_o = !smi_sync_ni && (hi_cnt == CNT_MAX);

  a_r1_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
  a_r2_low_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o && !smi_sync_ni |=> (hi_cnt != CNT_MAX) || !edge_o);
endmodule

// File: rtl/smi_ctrl.sv
module smi_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic boundary_i,
  input  logic wbuf_empty_i,
  input  logic resume_i,
  input  logic nmi_req_i,
  output logic take_o,
  output logic nmi_take_o,
  output logic smiact_o
);
  logic pend_q, in_smm_q, act_q;

  assign take_o     = boundary_i && pend_q && !in_smm_q;
  assign nmi_take_o = boundary_i && nmi_req_i && !take_o;

  // one-deep slot: a new edge refills it even in the cycle it is consumed
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= edge_i || (pend_q && !take_o);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       in_smm_q <= 1'b0;
    else if (take_o)   in_smm_q <= 1'b1;
    else if (resume_i) in_smm_q <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                        act_q <= 1'b0;
    else if (resume_i)                  act_q <= 1'b0;
    else if (in_smm_q && wbuf_empty_i)  act_q <= 1'b1;

  assign smiact_o = act_q;

  a_r5_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smiact_o |-> !take_o);
  a_r8_act_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smiact_o) |-> $past(wbuf_empty_i));
  a_r8_act_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_i && smiact_o |=> !smiact_o);
  a_r6_pend_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !take_o |=> pend_q);
endmodule

// File: rtl/smi_entry_unit.sv
module smi_entry_unit
  import smi_pkg::*;
#(
  parameter int    SYNC_STAGES = 2,
  parameter int    REARM_CLKS  = 4,
  parameter addr_t SMBASE_RST  = 32'h0003_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        smi_ni,
  input  logic        boundary_i,
  input  logic        wbuf_empty_i,
  input  logic        resume_i,
  input  logic        nmi_req_i,
  output logic        take_o,
  output logic        nmi_take_o,
  output logic        smiact_o,
  output logic [31:0] entry_addr_o
);
  logic smi_s_n, smi_edge;

  smi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (smi_ni),
    .q_o   (smi_s_n)
  );

  smi_edge #(.REARM_CLKS(REARM_CLKS)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smi_sync_ni(smi_s_n),
    .edge_o     (smi_edge)
  );

  smi_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (smi_edge),
    .boundary_i  (boundary_i),
    .wbuf_empty_i(wbuf_empty_i),
    .resume_i    (resume_i),
    .nmi_req_i   (nmi_req_i),
    .take_o      (take_o),
    .nmi_take_o  (nmi_take_o),
    .smiact_o    (smiact_o)
  );

  assign entry_addr_o = handler_entry(SMBASE_RST);

  a_r3_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> boundary_i);
  a_r5_mask_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !resume_i |=> !take_o);
endmodule

// File: tb/sim_smi_entry_unit.sv
module sim_smi_entry_unit;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic smi_ni = 1'b1, boundary_i = 1'b0, wbuf_empty_i = 1'b0;
  logic resume_i = 1'b0, nmi_req_i = 1'b0;
  logic take_o, nmi_take_o, smiact_o;
  logic [31:0] entry_addr_o;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  smi_entry_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .smi_ni(smi_ni), .boundary_i(boundary_i),
    .wbuf_empty_i(wbuf_empty_i), .resume_i(resume_i), .nmi_req_i(nmi_req_i),
    .take_o(take_o), .nmi_take_o(nmi_take_o), .smiact_o(smiact_o),
    .entry_addr_o(entry_addr_o)
  );

  // row: {smi_n, boundary, wbuf_empty, resume, nmi, exp_take, exp_nmi_take, exp_act}
  localparam int NV = 40;
  localparam logic [7:0] VEC [NV] = '{
    8'b11101_010, 8'b00100_000, 8'b01100_000, 8'b01101_010, // nmi alone, sync latency
    8'b01001_100, 8'b01000_000, 8'b10100_000, 8'b10000_001, // take beats nmi, mask, act
    8'b10000_001, 8'b00000_001, 8'b01000_001, 8'b00000_001, // 3-clock high pulse
    8'b00010_001, 8'b01000_000, 8'b10000_000, 8'b10000_000, // resume, short pulse ignored
    8'b10000_000, 8'b10000_000, 8'b00000_000, 8'b00000_000, // 4-clock high re-arm
    8'b00000_000, 8'b11001_100, 8'b10100_000, 8'b10000_001,
    8'b10000_001, 8'b01000_001, 8'b00000_001, 8'b00000_001, // edge while masked
    8'b11000_001, 8'b10000_001, 8'b10000_001, 8'b10000_001,
    8'b00000_001, 8'b00000_001, 8'b00000_001, 8'b01010_001, // second masked edge
    8'b01001_100, 8'b01000_000, 8'b00010_000, 8'b01000_000  // back-to-back, one only
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    smi_ni = 1'b1; boundary_i = 1'b0; wbuf_empty_i = 1'b0;
    resume_i = 1'b0; nmi_req_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    #1;
    check("R10 take in reset", take_o, 0);
    check("R10 act in reset", smiact_o, 0);
    check("R9 entry address", entry_addr_o, 32'h0003_8000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {smi_ni, boundary_i, wbuf_empty_i, resume_i, nmi_req_i} = VEC[i][7:3];
      #1;
      check($sformatf("R1 R2 R3 R4 R5 R6 take row %0d", i), take_o, VEC[i][2]);
      check($sformatf("R7 nmi row %0d", i), nmi_take_o, VEC[i][1]);
      check($sformatf("R8 act row %0d", i), smiact_o, VEC[i][0]);
    end

    // R4: boundary at edge k+2 misses, at k+3 takes
    @(negedge clk); idle();
    repeat (6) @(negedge clk);
    smi_ni = 1'b0;                 // sampled at edge k
    @(negedge clk); @(negedge clk);
    boundary_i = 1'b1; #1;         // sampled at edge k+2
    check("R4 too early", take_o, 0);
    @(negedge clk); #1;            // sampled at edge k+3
    check("R4 three clocks", take_o, 1);
    @(negedge clk); boundary_i = 1'b0; wbuf_empty_i = 1'b1;
    @(negedge clk); #1;
    check("R8 act after drain", smiact_o, 1);

    // R10: reset during management mode
    rst_ni = 1'b0; smi_ni = 1'b1; #1;
    check("R10 act cleared by reset", smiact_o, 0);
    @(negedge clk); rst_ni = 1'b1; wbuf_empty_i = 1'b0;
    boundary_i = 1'b1; #1;
    check("R10 no pending after reset", take_o, 0);
    @(negedge clk); #1;
    check("R10 act low after reset", smiact_o, 0);
    check("R9 entry address held", entry_addr_o, 32'h0003_8000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule